// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block holds five independent down-counters behind one small memory-mapped register window. Each channel has a count buffer, a compare buffer and a live count that software can read. Software writes a period into the count buffer and pulses the channel's manual-update bit to copy both buffers into the live state. It then sets start, either with auto-reload for periodic operation or without it for a single timeout.

Each channel moves one step down on a strobe from its own tick input. A tick that finds the live count at zero is an expiry. On expiry the channel latches its status bit. It then reloads its buffers and keeps running, or, with auto-reload clear, stays at zero. A single interrupt line carries the OR of the enabled status bits. Each channel also drives a level output that compares the live count with the live compare value. That level can be inverted.

Top module: `mdt_timer`

## Requirements
- R1: After synchronous reset, every buffer, live count, control bit, enable bit and status bit is zero, `irq` is 0 and `tmr_out` is all zero.
- R2: For channel n the count buffer sits at byte address 0x0C+12n and the compare buffer at 0x10+12n, and both read back what was written. The live count reads at 0x14+12n for n<4, and channel 4's live count reads at 0x40. A write to 0x40 lands in channel 4's compare buffer. Writes to the other live-count addresses change nothing.
- R3: While a channel's manual-update bit is set, each cycle copies its count buffer into the live count and its compare buffer into the live compare. No counting takes place while the bit is set.
- R4: The control word is at 0x08. Each channel owns a 4-bit group: bit 0 start, bit 1 manual update, bit 2 invert, bit 3 auto-reload. Channel 0 uses bits 3:0. Channel n>0 uses bits 4(n+1)+3 : 4(n+1). Bits 7:4 and 31:24 read as zero and control nothing.
- R5: With start and auto-reload set, a tick at zero reloads the buffers. A buffer value of P-1 therefore gives an expiry on every P-th tick.
- R6: Each tick on a running channel lowers a nonzero live count by one. Without auto-reload, the tick at zero expires once and the count stays at zero. Later ticks cause no further expiry until the next manual update.
- R7: Clearing start freezes the live count under ticks. Setting start again without manual update resumes counting from the frozen value.
- R8: The interrupt register is at 0x44, with enable in bits 4:0 and status in bits 9:5 (bit n+5 for channel n). An expiry sets the status bit one cycle after its tick, whatever the enable. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is 1 exactly when some channel has both its status bit and its enable bit set.
- R10: `tmr_out[n]` is 1 while the live count is greater than the live compare, XOR the channel's invert bit.
- R11: Buffers and counters are CNT_W bits wide (16 or 32). Wider write data is truncated, and reads are zero-extended. The count range is 0 to 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick | input | 5 | Per-channel count strobes |
| irq | output | 1 | Combined interrupt request |
| tmr_out | output | 5 | Per-channel compare level outputs |

## Verification
The assertions assume that ticks and register writes are single-cycle strobes sampled on the rising edge. They also assume that the control word seen by a channel is the registered one, so a write never changes a channel's behaviour in the cycle it is issued. The stimulus changes inputs only on falling edges. It holds a tick and a bus write apart from each other, and leaves a spare cycle after a manual-update write so the copy takes place before the next check.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

    localparam int NUM_CH  = 5;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int NIB_W   = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IRQ   = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_LIVE4 = 8'h40;

    // Per-channel control group; member order gives bit 3..0
    typedef struct packed {
        logic auto_rl;
        logic invert;
        logic manual;
        logic start;
    } ch_ctl_t;

    // What a channel does on a given cycle
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_DEC,
        ACT_RELOAD,
        ACT_STOP
    } ch_act_t;

    function automatic int ctl_group(input int ch);
        return (ch == 0) ? 0 : ch + 1;
    endfunction

    function automatic logic [ADDR_W-1:0] cnt_buf_addr(input int ch);
        return ADDR_W'(8'h0C + 12 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_buf_addr(input int ch);
        return ADDR_W'(8'h10 + 12 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] live_addr(input int ch);
        return (ch < 4) ? ADDR_W'(8'h14 + 12 * ch) : OFS_LIVE4;
    endfunction

endpackage

// File: rtl/mdt_channel.sv
module mdt_channel
    import mdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ch_ctl_t          ctl,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] live_cnt,
    output logic             expire,
    output logic             level
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             done_q;
    ch_act_t          act;

    always_comb begin
        act = ACT_HOLD;
        if (ctl.manual) begin
            act = ACT_LOAD;
        end else if (ctl.start && tick && !done_q) begin
            if (cnt_q == '0) begin
                act = ctl.auto_rl ? ACT_RELOAD : ACT_STOP;
            end else begin
                act = ACT_DEC;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            cmp_q  <= '0;
            done_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    cnt_q  <= cnt_buf;
                    cmp_q  <= cmp_buf;
                    done_q <= 1'b0;
                end
                ACT_RELOAD: begin
                    cnt_q <= cnt_buf;
                    cmp_q <= cmp_buf;
                end
                ACT_DEC:  cnt_q  <= cnt_q - 1'b1;
                ACT_STOP: done_q <= 1'b1;
                default:  ;
            endcase
        end
    end

    assign live_cnt = cnt_q;
    assign expire   = (act == ACT_RELOAD) || (act == ACT_STOP);
    assign level    = (cnt_q > cmp_q) ^ ctl.invert;

endmodule

// File: rtl/mdt_irq_ctl.sv
module mdt_irq_ctl
    import mdt_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   expire,
    input  logic           wr,
    input  logic [2*N-1:0] wdata,
    output logic [N-1:0]   enable,
    output logic [N-1:0]   status,
    output logic           irq
);

    logic [N-1:0] clr_mask;

    assign clr_mask = wr ? wdata[2*N-1:N] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            status <= '0;
        end else begin
            if (wr) begin
                enable <= wdata[N-1:0];
            end
            status <= (status & ~clr_mask) | expire;
        end
    end

    assign irq = |(status & enable);

endmodule

// File: rtl/mdt_regfile.sv
module mdt_regfile
    import mdt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N     = NUM_CH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [N-1:0][CNT_W-1:0]   live_cnt,
    input  logic [N-1:0]              enable,
    input  logic [N-1:0]              status,
    output ch_ctl_t [N-1:0]           ctl,
    output logic [N-1:0][CNT_W-1:0]   cnt_buf,
    output logic [N-1:0][CNT_W-1:0]   cmp_buf,
    output logic                      irq_wr,
    output logic [DATA_W-1:0]         rdata
);

    logic [N-1:0]      hit_cnt;
    logic [N-1:0]      hit_cmp;
    logic [N-1:0]      hit_live;
    logic              hit_ctrl;
    logic [DATA_W-1:0] ctrl_word;

    assign hit_ctrl = (addr == OFS_CTRL);
    assign irq_wr   = wr && (addr == OFS_IRQ);

    for (genvar g = 0; g < N; g++) begin : g_ch
        localparam int GRP = ctl_group(g);

        assign hit_cnt[g]  = (addr == cnt_buf_addr(g));
        assign hit_cmp[g]  = (addr == cmp_buf_addr(g));
        assign hit_live[g] = (addr == live_addr(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl[g]     <= '0;
                cnt_buf[g] <= '0;
                cmp_buf[g] <= '0;
            end else if (wr) begin
                if (hit_ctrl) begin
                    ctl[g] <= ch_ctl_t'(wdata[NIB_W*GRP +: NIB_W]);
                end
                if (hit_cnt[g]) begin
                    cnt_buf[g] <= wdata[CNT_W-1:0];
                end
                if (hit_cmp[g]) begin
                    cmp_buf[g] <= wdata[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        ctrl_word = '0;
        for (int c = 0; c < N; c++) begin
            ctrl_word[NIB_W*ctl_group(c) +: NIB_W] = ctl[c];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata = ctrl_word;
        end
        if (addr == OFS_IRQ) begin
            rdata = DATA_W'({status, enable});
        end
        for (int c = 0; c < N; c++) begin
            if (hit_cnt[c]) rdata = DATA_W'(cnt_buf[c]);
            if (hit_cmp[c]) rdata = DATA_W'(cmp_buf[c]);
        end
        // live count wins where an address is shared with a buffer
        for (int c = 0; c < N; c++) begin
            if (hit_live[c]) rdata = DATA_W'(live_cnt[c]);
        end
    end

endmodule

// File: rtl/mdt_timer.sv
module mdt_timer
    import mdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tick,
    output logic              irq,
    output logic [NUM_CH-1:0] tmr_out
);

    ch_ctl_t [NUM_CH-1:0]          ctl_w;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_buf_w;
    logic [NUM_CH-1:0][CNT_W-1:0]  cmp_buf_w;
    logic [NUM_CH-1:0][CNT_W-1:0]  live_w;
    logic [NUM_CH-1:0]             expire_w;
    logic [NUM_CH-1:0]             enable_w;
    logic [NUM_CH-1:0]             status_w;
    logic                          irq_wr_w;

    mdt_regfile #(
        .CNT_W (CNT_W),
        .N     (NUM_CH)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .live_cnt (live_w),
        .enable   (enable_w),
        .status   (status_w),
        .ctl      (ctl_w),
        .cnt_buf  (cnt_buf_w),
        .cmp_buf  (cmp_buf_w),
        .irq_wr   (irq_wr_w),
        .rdata    (bus_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        mdt_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl_w[g]),
            .tick     (tick[g]),
            .cnt_buf  (cnt_buf_w[g]),
            .cmp_buf  (cmp_buf_w[g]),
            .live_cnt (live_w[g]),
            .expire   (expire_w[g]),
            .level    (tmr_out[g])
        );
    end

    mdt_irq_ctl #(
        .N (NUM_CH)
    ) u_irq (
        .clk    (clk),
        .rst    (rst),
        .expire (expire_w),
        .wr     (irq_wr_w),
        .wdata  (bus_wdata[2*NUM_CH-1:0]),
        .enable (enable_w),
        .status (status_w),
        .irq    (irq)
    );

endmodule

// File: rtl/mdt_timer_chk.sv
module mdt_timer_chk
    import mdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_CH-1:0]             tick,
    input ch_ctl_t [NUM_CH-1:0]          ctl,
    input logic [NUM_CH-1:0][CNT_W-1:0]  live,
    input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_buf,
    input logic [NUM_CH-1:0]             status,
    input logic                          irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic run;
        assign run = ctl[g].start && !ctl[g].manual;

        // R3: manual update copies the count buffer
        a_r3_manual_load: assert property (@(posedge clk) disable iff (rst)
            ctl[g].manual |=> live[g] == $past(cnt_buf[g]));

        // R6: a running nonzero count steps down by one per tick
        a_r6_step_down: assert property (@(posedge clk) disable iff (rst)
            (run && tick[g] && live[g] != '0) |=> live[g] == $past(live[g]) - ONE);

        // R7: a stopped channel holds its count
        a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
            (!ctl[g].start && !ctl[g].manual) |=> $stable(live[g]));

        // R8: status only rises after a tick at zero on a running channel
        a_r8_status_source: assert property (@(posedge clk) disable iff (rst)
            $rose(status[g]) |-> $past(run && tick[g] && live[g] == '0));
    end

    // R9: the request needs some latched status
    a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0));

endmodule

bind mdt_timer mdt_timer_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .ctl     (ctl_w),
    .live    (live_w),
    .cnt_buf (cnt_buf_w),
    .status  (status_w),
    .irq     (irq)
);

// File: tb/mdt_timer_bench.sv
module mdt_timer_bench;

    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick = '0;
    logic        irq;
    logic [4:0]  tmr_out;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mdt_timer #(.CNT_W(CW)) u_mdt_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick      (tick),
        .irq       (irq),
        .tmr_out   (tmr_out)
    );

    function automatic logic [7:0] a_cnt(input int n);  return 8'(12 + 12 * n); endfunction
    function automatic logic [7:0] a_cmp(input int n);  return 8'(16 + 12 * n); endfunction
    function automatic logic [7:0] a_live(input int n); return (n < 4) ? 8'(20 + 12 * n) : 8'h40; endfunction
    function automatic logic [31:0] grp(input int n, input logic [3:0] bits);
        return 32'(bits) << (4 * ((n == 0) ? 0 : n + 1));
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [4:0] m);
        @(negedge clk);
        tick = m;
        @(negedge clk);
        tick = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(8'h08, d); chk(d, 0, "R1 ctrl");
        rd(8'h44, d); chk(d, 0, "R1 irq reg");
        for (int n = 0; n < 5; n++) begin
            rd(a_live(n), d); chk(d, 0, "R1 live");
            rd(a_cnt(n), d);  chk(d, 0, "R1 cnt buf");
        end
        chk(32'(irq), 0, "R1 irq pin");
        chk(32'(tmr_out), 0, "R1 tmr_out");

        // R4: control layout, unused groups read zero
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); chk(d, 32'h00FF_FF0F, "R4 ctrl readback");
        wr(8'h08, 0);

        // R2: buffer map and readback
        for (int n = 0; n < 5; n++) begin
            wr(a_cnt(n), 32'h100 + n);
            wr(a_cmp(n), 32'h200 + n);
        end
        for (int n = 0; n < 4; n++) begin
            rd(a_cnt(n), d); chk(d, 32'h100 + n, "R2 cnt buf");
            rd(a_cmp(n), d); chk(d, 32'h200 + n, "R2 cmp buf");
        end
        rd(a_cnt(4), d); chk(d, 32'h104, "R2 cnt buf ch4");
        rd(8'h40, d);    chk(d, 0, "R2 0x40 reads live ch4");
        wr(8'h14, 32'h77);
        rd(8'h14, d);    chk(d, 0, "R2 live write ignored");
        rd(8'h0C, d);    chk(d, 32'h100, "R2 buffer untouched by live write");

        // R4: group 1 controls nothing
        wr(8'h08, 32'h20);
        rd(a_live(1), d); chk(d, 0, "R4 group 1 no effect");
        // R3: manual update on every channel
        wr(8'h08, grp(0,2) | grp(1,2) | grp(2,2) | grp(3,2) | grp(4,2));
        for (int n = 0; n < 5; n++) begin
            rd(a_live(n), d); chk(d, 32'h100 + n, "R3 manual load");
        end
        pulse(5'h1F);
        rd(a_live(0), d); chk(d, 32'h100, "R3 no count while manual");
        wr(8'h08, 0);

        // R6: one-shot on channel 0, period 3
        wr(a_cnt(0), 2);
        wr(8'h08, grp(0, 4'h2));
        wr(8'h08, grp(0, 4'h1));
        pulse(5'h01); rd(a_live(0), d); chk(d, 1, "R6 step");
        pulse(5'h01); rd(a_live(0), d); chk(d, 0, "R6 step");
        rd(8'h44, d); chk(d, 0, "R6 no early expiry");
        pulse(5'h01); rd(8'h44, d); chk(d, 32'h20, "R8 status after expiry");
        rd(a_live(0), d); chk(d, 0, "R6 stays zero");
        wr(8'h44, 32'h20);
        rd(8'h44, d); chk(d, 0, "R8 w1c");
        pulse(5'h01); pulse(5'h01);
        rd(8'h44, d); chk(d, 0, "R6 no second expiry");
        rd(a_live(0), d); chk(d, 0, "R6 held at zero");
        wr(8'h08, 0);

        // R5: auto-reload sweep on channel 2
        for (int p = 1; p <= 5; p++) begin
            wr(a_cnt(2), 32'(p - 1));
            wr(8'h08, grp(2, 4'h2));
            wr(8'h08, grp(2, 4'h9));
            for (int t = 1; t <= 3 * p; t++) begin
                pulse(5'h04);
                rd(a_live(2), d); chk(d, 32'(p - 1 - (t % p)), "R5 count");
                rd(8'h44, d); chk(d, ((t % p) == 0) ? 32'h80 : 0, "R5 expiry period");
                if ((t % p) == 0) wr(8'h44, 32'h80);
            end
        end
        wr(8'h08, 0);

        // R7: freeze and resume on channel 3
        wr(a_cnt(3), 9);
        wr(8'h08, grp(3, 4'h2));
        wr(8'h08, grp(3, 4'h1));
        pulse(5'h08); pulse(5'h08);
        rd(a_live(3), d); chk(d, 7, "R7 running");
        wr(8'h08, 0);
        pulse(5'h08); pulse(5'h08); pulse(5'h08);
        rd(a_live(3), d); chk(d, 7, "R7 frozen");
        wr(8'h08, grp(3, 4'h1));
        pulse(5'h08);
        rd(a_live(3), d); chk(d, 6, "R7 resumed");
        wr(8'h08, 0);

        // R8/R9: enable and status on channel 1
        wr(a_cnt(1), 0);
        wr(8'h08, grp(1, 4'h2));
        wr(8'h08, grp(1, 4'h1));
        pulse(5'h02);
        rd(8'h44, d); chk(d, 32'h40, "R8 status without enable");
        chk(32'(irq), 0, "R9 masked");
        wr(8'h44, 32'h2);
        rd(8'h44, d); chk(d, 32'h42, "R8 zero write keeps status");
        chk(32'(irq), 1, "R9 asserted");
        wr(8'h44, 32'h42);
        rd(8'h44, d); chk(d, 32'h02, "R8 clear keeps enable");
        chk(32'(irq), 0, "R9 cleared");
        wr(8'h08, 0);
        wr(8'h44, 0);

        // R10: level sweep on channel 4
        wr(a_cnt(4), 5);
        for (int k = 0; k <= 6; k++) begin
            wr(8'h40, 32'(k));
            wr(8'h08, grp(4, 4'h2));
            @(negedge clk);
            chk(32'(tmr_out[4]), (5 > k) ? 1 : 0, "R10 level");
            wr(8'h08, grp(4, 4'h6));
            @(negedge clk);
            chk(32'(tmr_out[4]), (5 > k) ? 0 : 1, "R10 inverted");
        end
        wr(8'h08, 0);

        // R11: width truncation and maximum count
        wr(a_cnt(4), 32'hFFFF_FFFF);
        rd(a_cnt(4), d); chk(d, 32'h0000_FFFF, "R11 truncation");
        wr(8'h08, grp(4, 4'h2));
        wr(8'h08, grp(4, 4'h1));
        rd(8'h40, d); chk(d, 32'h0000_FFFF, "R11 max load");
        pulse(5'h10);
        rd(8'h40, d); chk(d, 32'h0000_FFFE, "R11 max step");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule